// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the instant at which a chosen event happens on an asynchronous input pin. It watches the pin through a synchroniser, finds its edges, and when the selected event occurs it copies the value of an external free-running 16-bit timer into a capture register. Each capture also sets a sticky request flag, which software clears with an explicit clear strobe.

A 4-bit mode field selects the event. The choices are every falling edge, every rising edge, every 4th rising edge, or every 16th rising edge. For the two divided modes a 4-bit edge prescaler counts rising edges. That counter is zeroed only by reset or by a mode outside the capture set. A direct switch from one divide ratio to the other keeps the running count, so the first capture after the switch can come early. Software is expected to pass through the off mode before changing the ratio, and to clear the flag after any mode change.

The register-style side has three parts: a write strobe with data for the mode field, a flag-clear strobe, and continuous readback of the mode, the captured value and the flag. Reading is passive and never alters state.

Top module: `cap_unit`

## Requirements
- R1: After reset the mode reads 4'b0000 (off), the captured value reads 16'h0000, the flag reads 0 and the prescaler count is zero.
- R2: Mode codes are 4'b0100 falling edge, 4'b0101 rising edge, 4'b0110 every 4th rising edge and 4'b0111 every 16th rising edge. Any other code, including 4'b0000, makes no capture.
- R3: In falling-edge mode every falling edge of the pin captures, and rising edges do not.
- R4: In rising-edge mode every rising edge of the pin captures, and falling edges do not.
- R5: In divide-by-4 mode, starting from a zero count, a capture happens on every 4th rising edge and on no other.
- R6: In divide-by-16 mode, starting from a zero count, a capture happens on every 16th rising edge and on no other.
- R7: A capture loads all 16 timer bits at once, taking the timer value present at the load edge, and sets the flag. A pin change made just after a clock edge shows up in the flag and value at the 4th rising clock edge that follows: two synchroniser stages, one detect register and one load.
- R8: With no capture, the captured value holds. A new capture overwrites the old value even if the flag is still set.
- R9: The flag stays set until a clear strobe arrives, and it reads 0 on the cycle after the strobe.
- R10: When a clear strobe and a capture fall in the same cycle, the flag stays set.
- R11: The prescaler count returns to zero whenever the mode is off or is a non-capture code, so a later divided mode counts afresh.
- R12: A direct switch between the divide-by-4 and divide-by-16 codes keeps the count. Each rising edge in a divided mode increments the 4-bit count, and a capture fires when the incremented count has zero in its low 2 bits (divide-by-4) or in all 4 bits (divide-by-16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 4 | New mode code |
| flag_clr | input | 1 | Clear strobe for the capture flag |
| timer_val | input | 16 | Current value of the free-running timer |
| cap_pin | input | 1 | Raw asynchronous capture input |
| mode_q | output | 4 | Readback of the mode field |
| cap_val | output | 16 | Timer value latched at the last capture |
| cap_flag | output | 1 | Sticky capture request flag |

## Verification
A corrupted prescaler count is invisible until a divided mode reaches its wrap point. Its only port-level symptom is a capture that arrives one or more edges too early or too late, so the bench counts edges exactly and looks at the flag after each one. A synchroniser or detect-stage fault moves the flag by whole cycles, so the latency check samples both the cycle before the expected update and the cycle of it. Flag priority faults show only when a clear and a capture coincide, and the bench stages that collision deliberately.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int MODE_W = 4;
    localparam int PRE_W  = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF    = 4'b0000,
        MODE_FALL   = 4'b0100,
        MODE_RISE   = 4'b0101,
        MODE_RISE4  = 4'b0110,
        MODE_RISE16 = 4'b0111
    } cap_mode_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_FALL,
        EV_RISE,
        EV_RISE_DIV
    } ev_kind_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_s;

    typedef struct packed {
        ev_kind_e          kind;
        logic [PRE_W-1:0]  mask;
    } sel_s;

    function automatic sel_s decode_mode(input logic [MODE_W-1:0] m);
        sel_s s;
        s.kind = EV_NONE;
        s.mask = '0;
        case (m)
            MODE_FALL:   s.kind = EV_FALL;
            MODE_RISE:   s.kind = EV_RISE;
            MODE_RISE4: begin
                s.kind = EV_RISE_DIV;
                s.mask = PRE_W'(3);
            end
            MODE_RISE16: begin
                s.kind = EV_RISE_DIV;
                s.mask = PRE_W'(15);
            end
            default:     s.kind = EV_NONE;
        endcase
        return s;
    endfunction

    function automatic logic is_capture(input logic [MODE_W-1:0] m);
        return decode_mode(m).kind != EV_NONE;
    endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pin,
    output cap_pkg::edge_s edges
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[CHAIN-2:0], pin};
        end
    end

    // chain[STAGES-1] is the synchronised pin, chain[STAGES] its previous value
    always_comb begin
        edges.rise = chain[STAGES-1] & ~chain[STAGES];
        edges.fall = ~chain[STAGES-1] & chain[STAGES];
    end

endmodule

// File: rtl/cap_prescale.sv
module cap_prescale
    import cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  edge_s             edges,
    output logic              evt_q,
    output logic [PRE_W-1:0]  cnt
);
    sel_s             sel;
    logic [PRE_W-1:0] cnt_inc;
    logic [PRE_W-1:0] cnt_nxt;
    logic             fire;

    always_comb begin
        sel     = decode_mode(mode);
        cnt_inc = cnt + 1'b1;
        cnt_nxt = cnt;
        fire    = 1'b0;
        case (sel.kind)
            EV_NONE:  cnt_nxt = '0;
            EV_FALL:  fire = edges.fall;
            EV_RISE:  fire = edges.rise;
            EV_RISE_DIV: begin
                if (edges.rise) begin
                    cnt_nxt = cnt_inc;
                    fire    = ((cnt_inc & sel.mask) == '0);
                end
            end
            default:  cnt_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            evt_q <= 1'b0;
        end else begin
            cnt   <= cnt_nxt;
            evt_q <= fire;
        end
    end

endmodule

// File: rtl/cap_regs.sv
module cap_regs #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          evt,
    input  logic          flag_clr,
    input  logic [TW-1:0] timer_val,
    output logic [TW-1:0] cap_val,
    output logic          cap_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_val <= '0;
        end else if (evt) begin
            cap_val <= timer_val;
        end
    end

    // a new capture takes priority over a clear strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_flag <= 1'b0;
        end else if (evt) begin
            cap_flag <= 1'b1;
        end else if (flag_clr) begin
            cap_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/cap_unit.sv
module cap_unit
    import cap_pkg::*;
#(
    parameter int TW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              flag_clr,
    input  logic [TW-1:0]     timer_val,
    input  logic              cap_pin,
    output logic [MODE_W-1:0] mode_q,
    output logic [TW-1:0]     cap_val,
    output logic              cap_flag
);
    edge_s            edges;
    logic             evt_q;
    logic [PRE_W-1:0] pre_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_OFF;
        end else if (mode_wr) begin
            mode_q <= mode_wdata;
        end
    end

    cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin   (cap_pin),
        .edges (edges)
    );

    cap_prescale u_pre (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode_q),
        .edges (edges),
        .evt_q (evt_q),
        .cnt   (pre_cnt)
    );

    cap_regs #(.TW(TW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt_q),
        .flag_clr  (flag_clr),
        .timer_val (timer_val),
        .cap_val   (cap_val),
        .cap_flag  (cap_flag)
    );

endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk
    import cap_pkg::*;
#(
    parameter int TW = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [MODE_W-1:0] mode_q,
    input logic              flag_clr,
    input logic [TW-1:0]     timer_val,
    input logic [TW-1:0]     cap_val,
    input logic              cap_flag,
    input logic              evt,
    input logic [PRE_W-1:0]  pre_cnt
);
    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        evt |=> (cap_val == $past(timer_val) && cap_flag));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !evt |=> $stable(cap_val));

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (cap_flag && !flag_clr) |=> cap_flag);

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !evt) |=> !cap_flag);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && evt) |=> cap_flag);

    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !is_capture(mode_q) |=> !evt);

    p_cnt_zero_r11: assert property (@(posedge clk) disable iff (rst)
        !is_capture(mode_q) |=> (pre_cnt == '0));

endmodule

bind cap_unit cap_unit_chk #(.TW(TW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_q    (mode_q),
    .flag_clr  (flag_clr),
    .timer_val (timer_val),
    .cap_val   (cap_val),
    .cap_flag  (cap_flag),
    .evt       (evt_q),
    .pre_cnt   (pre_cnt)
);

// File: tb/cap_unit_test.sv
`timescale 1ns/1ps
module cap_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr = 1'b0;
    logic [3:0]  mode_wdata = 4'b0000;
    logic        flag_clr = 1'b0;
    logic [15:0] timer_val = 16'h0000;
    logic        cap_pin = 1'b0;
    logic [3:0]  mode_q;
    logic [15:0] cap_val;
    logic        cap_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cap_unit uut (
        .clk        (clk),
        .rst        (rst),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .flag_clr   (flag_clr),
        .timer_val  (timer_val),
        .cap_pin    (cap_pin),
        .mode_q     (mode_q),
        .cap_val    (cap_val),
        .cap_flag   (cap_flag)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mode(input logic [3:0] m);
        @(negedge clk);
        mode_wr = 1'b1;
        mode_wdata = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic rise();
        @(negedge clk);
        cap_pin = 1'b1;
        wait_n(6);
    endtask

    task automatic fall();
        @(negedge clk);
        cap_pin = 1'b0;
        wait_n(6);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            rise();
            fall();
        end
    endtask

    // R1
    task automatic t_reset();
        check(mode_q == 4'b0000, "R1 mode", 32'(mode_q), 32'h0);
        check(cap_val == 16'h0000, "R1 value", 32'(cap_val), 32'h0);
        check(cap_flag == 1'b0, "R1 flag", 32'(cap_flag), 32'h0);
    endtask

    // R2
    task automatic t_no_capture_codes();
        timer_val = 16'h5A5A;
        pulses(2);
        check(cap_flag == 1'b0, "R2 off code flag", 32'(cap_flag), 32'h0);
        write_mode(4'b1010);
        check(mode_q == 4'b1010, "R2 mode readback", 32'(mode_q), 32'hA);
        pulses(2);
        check(cap_flag == 1'b0, "R2 unused code flag", 32'(cap_flag), 32'h0);
        check(cap_val == 16'h0000, "R2 unused code value", 32'(cap_val), 32'h0);
    endtask

    // R7 latency and full-width load
    task automatic t_latency();
        write_mode(4'b0101);
        clear_flag();
        timer_val = 16'h1234;
        @(negedge clk);
        cap_pin = 1'b1;
        wait_n(3);
        check(cap_flag == 1'b0, "R7 flag before 4th edge", 32'(cap_flag), 32'h0);
        wait_n(1);
        check(cap_flag == 1'b1, "R7 flag at 4th edge", 32'(cap_flag), 32'h1);
        check(cap_val == 16'h1234, "R7 value", 32'(cap_val), 32'h1234);
        wait_n(4);
        fall();
    endtask

    // R4
    task automatic t_rise_only();
        write_mode(4'b0101);
        clear_flag();
        timer_val = 16'hAAAA;
        rise();
        check(cap_flag == 1'b1 && cap_val == 16'hAAAA, "R4 rising capture", 32'(cap_val), 32'hAAAA);
        clear_flag();
        timer_val = 16'hBBBB;
        fall();
        check(cap_flag == 1'b0, "R4 falling ignored flag", 32'(cap_flag), 32'h0);
        check(cap_val == 16'hAAAA, "R4 falling ignored value", 32'(cap_val), 32'hAAAA);
    endtask

    // R3
    task automatic t_fall_only();
        write_mode(4'b0100);
        clear_flag();
        timer_val = 16'hC001;
        rise();
        check(cap_flag == 1'b0, "R3 rising ignored", 32'(cap_flag), 32'h0);
        fall();
        check(cap_flag == 1'b1 && cap_val == 16'hC001, "R3 falling capture", 32'(cap_val), 32'hC001);
    endtask

    // R8
    task automatic t_overwrite();
        write_mode(4'b0101);
        clear_flag();
        timer_val = 16'h1111;
        pulses(1);
        timer_val = 16'h2222;
        pulses(1);
        check(cap_val == 16'h2222, "R8 overwrite", 32'(cap_val), 32'h2222);
        timer_val = 16'h3333;
        wait_n(5);
        check(cap_val == 16'h2222, "R8 hold", 32'(cap_val), 32'h2222);
    endtask

    // R9
    task automatic t_sticky();
        wait_n(20);
        check(cap_flag == 1'b1, "R9 sticky", 32'(cap_flag), 32'h1);
        clear_flag();
        check(cap_flag == 1'b0, "R9 cleared", 32'(cap_flag), 32'h0);
    endtask

    // R10
    task automatic t_set_wins();
        write_mode(4'b0101);
        clear_flag();
        timer_val = 16'h4444;
        @(negedge clk);
        cap_pin = 1'b1;
        wait_n(3);
        flag_clr = 1'b1;
        wait_n(1);
        flag_clr = 1'b0;
        check(cap_flag == 1'b1, "R10 capture beats clear", 32'(cap_flag), 32'h1);
        check(cap_val == 16'h4444, "R10 value", 32'(cap_val), 32'h4444);
        wait_n(2);
        fall();
    endtask

    task automatic expect_div(input int edges_needed, input string req, input logic [15:0] tv);
        timer_val = tv;
        pulses(edges_needed - 1);
        check(cap_flag == 1'b0, {req, " no early capture"}, 32'(cap_flag), 32'h0);
        pulses(1);
        check(cap_flag == 1'b1 && cap_val == tv, {req, " capture on edge"}, 32'(cap_val), 32'(tv));
        clear_flag();
    endtask

    // R5
    task automatic t_div4();
        write_mode(4'b0000);
        write_mode(4'b0110);
        clear_flag();
        expect_div(4, "R5 first", 16'h0404);
        expect_div(4, "R5 second", 16'h0808);
    endtask

    // R6
    task automatic t_div16();
        write_mode(4'b0000);
        write_mode(4'b0111);
        clear_flag();
        expect_div(16, "R6", 16'h1616);
    endtask

    // R11
    task automatic t_clear_on_off();
        write_mode(4'b0000);
        write_mode(4'b0110);
        clear_flag();
        pulses(2);
        write_mode(4'b0000);
        write_mode(4'b0110);
        clear_flag();
        expect_div(4, "R11 off clears count", 16'h0B0B);
        pulses(2);
        write_mode(4'b1111);
        write_mode(4'b0110);
        clear_flag();
        expect_div(4, "R11 unused code clears count", 16'h0C0C);
    endtask

    // R12
    task automatic t_switch();
        write_mode(4'b0000);
        write_mode(4'b0111);
        clear_flag();
        pulses(2);
        write_mode(4'b0110);
        clear_flag();
        expect_div(2, "R12 16 to 4 early", 16'h1204);
        write_mode(4'b0111);
        clear_flag();
        expect_div(12, "R12 4 to 16 early", 16'h1216);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_capture_codes();
        t_latency();
        t_rise_only();
        t_fall_only();
        t_overwrite();
        t_sticky();
        t_set_wins();
        t_div4();
        t_div16();
        t_clear_on_off();
        t_switch();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

endmodule